// File: doc/BRIEF.md
# Limit-Compare Interval Timer Bank

This block is a bank of register-mapped interval timers. One system timer drives the level-10 interrupt line. Each of `NUM_CPU` processor timers drives its own level-14 interrupt line. Every timer has three registers. A count register advances on each prescaled `tick`. A limit register holds the compare value, and reading it acknowledges the pending interrupt. A second limit view returns and updates the same limit but leaves the count and the pending flag alone.

A mode register in the system block picks, for each processor timer, one of two modes. In limit mode the timer fires periodically. In free-running user mode the timer is a plain counter that a run bit starts and stops. Software arms a periodic interrupt by writing a limit. It services the interrupt by reading that limit back. The system count can be read at any moment as a monotonic time base.

Limits and counts are `LIM_W` bits wide and sit in the top bits of the `DATA_W`-bit data word. The bits below them always read as zero.

Top module: `itmr_set`

## Requirements
- R1: After reset all counts, limits, pending flags, run bits and the mode register are zero, and `irq_sys` and `irq_cpu` are low.
- R2: In limit mode with a non-zero limit L, each tick adds one to the count. A tick that takes the count to L sets the pending flag. The tick after that returns the count to 1, so after a limit write the flag sets on the L-th tick and then every L ticks.
- R3: The pending flag is sticky until it is acknowledged or the limit is rewritten. `irq_sys` shows the system flag (level 10), and `irq_cpu[i]` shows processor timer i (level 14).
- R4: Reading the limit register (sub-address 0) returns the limit in bits DATA_W-1..DATA_W-LIM_W, with zeros below, and clears that timer's flag. If the flag sets in the same cycle, setting wins.
- R5: Reading the no-clear limit view (sub-address 2) returns the same value as the limit register and leaves the flag set.
- R6: Writing the limit register loads the limit, zeroes the count and clears the flag.
- R7: Writing the no-clear view loads the limit and leaves the count and the flag unchanged.
- R8: A limit of zero disables interrupt generation. The count keeps advancing and wraps at its full width.
- R9: The mode register (system block, sub-address 3) selects the mode per timer. Bit i = 1 puts processor timer i in user mode. Writing zero returns every processor timer to limit mode.
- R10: In user mode, bit 0 of the processor timer's control register (sub-address 3) must be 1 for ticks to count. The count passes the limit without wrapping, and no interrupt is raised.
- R11: A count register (sub-address 1) can be read at any time with no side effect. Writes to it are ignored.
- R12: The address is {block, sub-address[1:0]}. Blocks 0..NUM_CPU-1 are the processor timers, and block NUM_CPU is the system timer. `rdata` is valid in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | {block, sub-address} |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after rd_en |
| irq_sys | output | 1 | System timer interrupt, level 10 |
| irq_cpu | output | NUM_CPU | Per-processor interrupts, level 14 |

## Verification
The limit compare is exercised with several patterns, and each separates a different behaviour:
- A short limit ticked past its match tells the return-to-one reload apart from a wrap to zero.
- Lowering the limit through the no-clear view while the count is mid-period shows that the count is kept and the new limit is used.
- A zero limit ticked many times shows that counting goes on while interrupts stay off.
- A timer switched into user mode, ticked first stopped and then running past its limit, tells the mode gate apart from the compare.
- A read acknowledge that lands on the same tick as a match exposes the set-over-clear priority.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

   typedef enum logic [1:0] {
      RS_LIMIT = 2'd0,
      RS_COUNT = 2'd1,
      RS_NOCLR = 2'd2,
      RS_CTRL  = 2'd3
   } reg_sel_e;

   localparam int SYS_LEVEL = 10;
   localparam int CPU_LEVEL = 14;

endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
   parameter int LIM_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             user_mode,
   input  logic             run,
   input  logic             wr_limit,
   input  logic             wr_noclr,
   input  logic [LIM_W-1:0] wr_val,
   input  logic             ack,
   output logic [LIM_W-1:0] limit_o,
   output logic [LIM_W-1:0] count_o,
   output logic             flag_o
);
   localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

   logic [LIM_W-1:0] lim_q, cnt_q, cnt_nxt;
   logic             flag_q, adv, hit, lim_on;

   assign lim_on = (lim_q != '0);
   assign adv    = tick && (!user_mode || run);

   always_comb begin
      if (!user_mode && lim_on && cnt_q == lim_q) cnt_nxt = ONE;
      else                                         cnt_nxt = cnt_q + ONE;
   end

   assign hit = adv && !user_mode && lim_on && (cnt_nxt == lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q  <= '0;
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (wr_limit) begin
         lim_q  <= wr_val;
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_noclr) lim_q <= wr_val;
         if (adv)      cnt_q <= cnt_nxt;
         if (hit)      flag_q <= 1'b1;
         else if (ack) flag_q <= 1'b0;
      end
   end

   assign limit_o = lim_q;
   assign count_o = cnt_q;
   assign flag_o  = flag_q;
endmodule

// File: rtl/itmr_rdmux.sv
module itmr_rdmux
   import itmr_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 32,
   parameter int LIM_W   = 22,
   localparam int NBLK   = NUM_CPU + 1,
   localparam int BLK_W  = $clog2(NBLK),
   localparam int LSB    = DATA_W - LIM_W
) (
   input  logic [BLK_W-1:0]   blk,
   input  reg_sel_e           sel,
   input  logic [LIM_W-1:0]   lim   [NBLK],
   input  logic [LIM_W-1:0]   cnt   [NBLK],
   input  logic [NUM_CPU-1:0] run,
   input  logic [NUM_CPU-1:0] cfg,
   output logic [DATA_W-1:0]  rval
);
   always_comb begin
      rval = '0;
      for (int b = 0; b < NBLK; b++) begin
         if (blk == BLK_W'(b)) begin
            unique case (sel)
               RS_LIMIT, RS_NOCLR: rval = {lim[b], {LSB{1'b0}}};
               RS_COUNT:           rval = {cnt[b], {LSB{1'b0}}};
               RS_CTRL: begin
                  if (b == NUM_CPU) rval = DATA_W'(cfg);
                  else              rval = DATA_W'(run[b]);
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/itmr_set.sv
module itmr_set
   import itmr_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 32,
   parameter int LIM_W   = 22,
   localparam int NBLK   = NUM_CPU + 1,
   localparam int BLK_W  = $clog2(NBLK),
   localparam int ADDR_W = BLK_W + 2,
   localparam int LSB    = DATA_W - LIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_sys,
   output logic [NUM_CPU-1:0] irq_cpu
);
   if (NUM_CPU < 1) begin : g_bad_cpu
      $error("itmr_set: NUM_CPU must be at least 1");
   end
   if (LIM_W < 2 || LIM_W >= DATA_W) begin : g_bad_lim
      $error("itmr_set: LIM_W must lie in 2..DATA_W-1");
   end
   if (NUM_CPU > LSB) begin : g_bad_cfg
      $error("itmr_set: mode bits must fit below the limit field");
   end

   logic [BLK_W-1:0]   blk;
   reg_sel_e           sel;
   logic [LIM_W-1:0]   lim_q [NBLK];
   logic [LIM_W-1:0]   cnt_q [NBLK];
   logic [NBLK-1:0]    flag;
   logic [NUM_CPU-1:0] cfg_q, run_q;
   logic [DATA_W-1:0]  rval;
   logic [LIM_W-1:0]   glb_cnt;
   logic               wdata_unused;

   assign blk          = addr[ADDR_W-1:2];
   assign sel          = reg_sel_e'(addr[1:0]);
   assign wdata_unused = ^wdata;

   for (genvar g = 0; g < NBLK; g++) begin : g_tmr
      logic hit_blk, mode_u, run_b;
      assign hit_blk = (blk == BLK_W'(g));
      if (g == NUM_CPU) begin : g_sys
         assign mode_u = 1'b0;
         assign run_b  = 1'b1;
      end else begin : g_cpu
         assign mode_u = cfg_q[g];
         assign run_b  = run_q[g];
      end
      itmr_counter #(.LIM_W(LIM_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .user_mode (mode_u),
         .run       (run_b),
         .wr_limit  (wr_en && hit_blk && sel == RS_LIMIT),
         .wr_noclr  (wr_en && hit_blk && sel == RS_NOCLR),
         .wr_val    (wdata[DATA_W-1:LSB]),
         .ack       (rd_en && hit_blk && sel == RS_LIMIT),
         .limit_o   (lim_q[g]),
         .count_o   (cnt_q[g]),
         .flag_o    (flag[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         run_q <= '0;
      end else if (wr_en && sel == RS_CTRL) begin
         if (blk == BLK_W'(NUM_CPU)) begin
            cfg_q <= wdata[NUM_CPU-1:0];
         end else begin
            for (int c = 0; c < NUM_CPU; c++) begin
               if (blk == BLK_W'(c)) run_q[c] <= wdata[0];
            end
         end
      end
   end

   itmr_rdmux #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .LIM_W(LIM_W)) u_rd (
      .blk  (blk),
      .sel  (sel),
      .lim  (lim_q),
      .cnt  (cnt_q),
      .run  (run_q),
      .cfg  (cfg_q),
      .rval (rval)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rval;
   end

   assign glb_cnt = cnt_q[NUM_CPU];
   assign irq_sys = flag[NUM_CPU];
   assign irq_cpu = flag[NUM_CPU-1:0];
endmodule

// File: rtl/itmr_set_chk.sv
module itmr_set_chk #(
   parameter int NUM_CPU = 4,
   parameter int LIM_W   = 22,
   parameter int ADDR_W  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               rd_en,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic               irq_sys,
   input logic [NUM_CPU-1:0] irq_cpu,
   input logic [NUM_CPU-1:0] cfg_q,
   input logic [LIM_W-1:0]   glb_cnt
);
   localparam logic [ADDR_W-1:0] G_LIM = {(ADDR_W-2)'(NUM_CPU), 2'd0};

   logic g_lim_wr, g_lim_rd;
   assign g_lim_wr = wr_en && addr == G_LIM;
   assign g_lim_rd = rd_en && addr == G_LIM;

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !g_lim_wr |=> (glb_cnt == LIM_W'($past(glb_cnt) + 1'b1)) || (glb_cnt == LIM_W'(1))); // R2

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sys && !g_lim_wr && !g_lim_rd |=> irq_sys); // R3

   AST_LIMIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      g_lim_rd && !tick && !wr_en |=> !irq_sys); // R4

   AST_LIMIT_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      g_lim_wr |=> !irq_sys && glb_cnt == '0); // R6

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !wr_en |=> $stable(glb_cnt)); // R11

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_user
      AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_q[i] && !irq_cpu[i] |=> !irq_cpu[i]); // R10
   end
endmodule

bind itmr_set itmr_set_chk #(.NUM_CPU(NUM_CPU), .LIM_W(LIM_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .rd_en   (rd_en),
   .wr_en   (wr_en),
   .addr    (addr),
   .irq_sys (irq_sys),
   .irq_cpu (irq_cpu),
   .cfg_q   (cfg_q),
   .glb_cnt (glb_cnt)
);

// File: tb/itmr_set_tb.sv
module itmr_set_tb;
   localparam int CLK_P = 10;
   localparam int NCPU  = 4;
   localparam int G     = NCPU;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_sys;
   logic [3:0]  irq_cpu;
   int          total = 0, bad = 0;
   logic [31:0] d;

   always #(CLK_P/2) clk = ~clk;

   itmr_set u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_sys(irq_sys), .irq_cpu(irq_cpu)
   );

   function automatic logic [4:0] ad(int b, int s);
      return {3'(b), 2'(s)};
   endfunction

   function automatic logic [31:0] lv(int v);
      return {22'(v), 10'b0};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] v);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] v);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; v = rdata;
   endtask

   task automatic rd_tick(logic [4:0] a, output logic [31:0] v);
      @(negedge clk); rd_en = 1'b1; tick = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; tick = 1'b0; v = rdata;
   endtask

   task automatic ticks(int n);
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 irq_sys", 32'(irq_sys), 0);
      chk("R1 irq_cpu", 32'(irq_cpu), 0);
      rd(ad(G, 1), d);    chk("R1 sys count", d, 0);
      rd(ad(0, 0), d);    chk("R1 cpu0 limit", d, 0);
      rd(ad(G, 3), d);    chk("R1 mode reg", d, 0);
   endtask

   task automatic t_period();
      wr(ad(G, 0), lv(5));
      ticks(4);
      chk("R2 no irq before limit", 32'(irq_sys), 0);
      rd(ad(G, 1), d);    chk("R2 R11 count 4", d, lv(4));
      ticks(1);
      chk("R2 irq at limit", 32'(irq_sys), 1);
      ticks(1);
      rd(ad(G, 1), d);    chk("R2 reload to 1", d, lv(1));
      chk("R3 sticky", 32'(irq_sys), 1);
      ticks(4);
   endtask

   task automatic t_ack();
      rd(ad(G, 2), d);    chk("R5 noclear value", d, lv(5));
      chk("R5 flag kept", 32'(irq_sys), 1);
      rd(ad(G, 0), d);    chk("R4 limit value", d, lv(5));
      chk("R4 flag cleared", 32'(irq_sys), 0);
   endtask

   task automatic t_writes();
      ticks(1);
      wr(ad(G, 2), lv(3));
      rd(ad(G, 1), d);    chk("R7 count kept", d, lv(1));
      ticks(2);
      chk("R7 new limit used", 32'(irq_sys), 1);
      wr(ad(G, 2), lv(9));
      chk("R7 flag kept", 32'(irq_sys), 1);
      wr(ad(G, 0), lv(7));
      chk("R6 flag cleared", 32'(irq_sys), 0);
      rd(ad(G, 1), d);    chk("R6 count zero", d, 0);
      wr(ad(G, 1), 32'h1234_5400);
      rd(ad(G, 1), d);    chk("R11 count write ignored", d, 0);
   endtask

   task automatic t_zero();
      wr(ad(G, 0), 0);
      ticks(10);
      chk("R8 no irq", 32'(irq_sys), 0);
      rd(ad(G, 1), d);    chk("R8 count runs", d, lv(10));
   endtask

   task automatic t_percpu();
      for (int c = 0; c < NCPU; c++) wr(ad(c, 0), (c == 1) ? lv(3) : 0);
      ticks(3);
      chk("R12 only cpu1 fires", 32'(irq_cpu), 32'b0010);
      chk("R12 sys quiet", 32'(irq_sys), 0);
   endtask

   task automatic t_user();
      wr(ad(G, 3), 32'b0100);
      wr(ad(2, 0), lv(2));
      ticks(3);
      rd(ad(2, 1), d);    chk("R10 stopped", d, 0);
      wr(ad(2, 3), 1);
      ticks(5);
      rd(ad(2, 1), d);    chk("R10 runs past limit", d, lv(5));
      chk("R10 no irq", 32'(irq_cpu[2]), 0);
      rd(ad(2, 3), d);    chk("R10 run bit", d, 1);
      rd(ad(G, 3), d);    chk("R9 mode readback", d, 32'b0100);
      wr(ad(G, 3), 0);
      wr(ad(2, 0), lv(2));
      ticks(2);
      chk("R9 back to limit mode", 32'(irq_cpu[2]), 1);
   endtask

   task automatic t_lowbits();
      wr(ad(3, 0), 32'hFFFF_FFFF);
      rd(ad(3, 2), d);    chk("R4 low bits zero", d, 32'hFFFF_FC00);
   endtask

   task automatic t_race();
      wr(ad(0, 0), lv(2));
      ticks(1);
      rd_tick(ad(0, 0), d);
      chk("R4 read value", d, lv(2));
      chk("R4 set beats ack", 32'(irq_cpu[0]), 1);
      rd(ad(0, 0), d);
      chk("R4 later ack clears", 32'(irq_cpu[0]), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_period();
      t_ack();
      t_writes();
      t_zero();
      t_percpu();
      t_user();
      t_lowbits();
      t_race();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule